// File: doc/BRIEF.md
# Two-Channel Receive Byte Router

This block sits on the host side of a controller that serves two serial input devices, a primary one (typically keys) and a secondary one (typically a pointer), through one shared output byte. On each service pulse it looks at the controller's status byte. If the status says a byte is waiting, the block takes the data byte and signals that it has consumed it. A source flag in the same status byte then decides which of two channel rings receives the byte.

Each channel has its own 64-slot circular store and its own enable. It also offers an available flag, a read strobe with a registered read-data output, and a saturating count of bytes lost to a full ring. A service pulse that finds no byte waiting adds to a shared saturating counter of spurious events. Software or a downstream engine drains each channel on its own. Clearing a channel's enable empties that channel at once.

Top module: `rx_ring_demux`

## Requirements
- R1: After reset, both available flags are 0, both read-data outputs are 0, and both loss counters and the spurious-event counter are 0.
- R2: A taken byte goes to channel 1 when status bit 5 (mask 0x20) is 1, and to channel 0 when that bit is 0.
- R3: A byte is taken, with `data_rd_o` high in the same cycle, only when `svc_i` is high and status bit 0 (mask 0x01) is 1. A service pulse with bit 0 low takes no byte, leaves both rings unchanged, and adds 1 to `unclaimed_o`.
- R4: Each channel returns its bytes in arrival order. It holds at most 63 bytes: the ring has 64 slots and one of them always stays free.
- R5: A byte taken for a channel that already holds 63 bytes is dropped. The stored bytes are not changed, and that channel's loss counter goes up by 1.
- R6: A byte taken for a channel whose enable is low is still consumed (`data_rd_o` high). It is not stored and does not change that channel's loss counter.
- R7: A read strobe on an empty channel gives read data 0 on the next cycle and moves no pointer.
- R8: While a channel's enable is low, both of its pointers are held at 0. That channel then reads as empty from the next cycle on and returns no old data after it is enabled again.
- R9: A channel's available flag is high exactly when its read and write pointers differ. It rises in the cycle after the first byte is stored.
- R10: The loss counters and the spurious-event counter are 16 bits wide and stop at 0xFFFF.
- R11: The pointers wrap modulo 64. Byte order is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| svc_i | input | 1 | Service event strobe |
| stat_i | input | 8 | Controller status byte (bit 0 byte waiting, bit 5 secondary source) |
| data_i | input | 8 | Controller data byte |
| data_rd_o | output | 1 | Data byte consumed this cycle |
| chan_en_i | input | 2 | Per-channel enable; low clears that channel |
| rd_i | input | 2 | Per-channel read strobe |
| avail_o | output | 2 | Per-channel data-available flag |
| rd_data_o | output | 16 | Per-channel read data, 8 bits per channel, registered |
| overrun_o | output | 32 | Per-channel 16-bit saturating loss counter |
| unclaimed_o | output | 16 | Saturating count of service events with no byte waiting |

## Verification
The bench fills a channel to exactly 63 bytes and then pushes more. A design that kept the wrong free-slot rule would either store a 64th byte or drop the 63rd, and the drain order would show it. It sends more than 64 bytes through one ring, so a pointer that wraps wrongly gives bytes out of order. It pushes tens of thousands of surplus bytes to drive the loss counter past 0xFFFF, so a counter without saturation would roll over to a small value. It also disables and re-enables a channel that holds data, reads empty channels, and sends bytes to a disabled channel. These steps catch stale data coming back, a nonzero empty read, and bytes stored or counted for a channel that is off.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned RING_D   = 64;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned OBF_BIT  = 0;
  localparam int unsigned SRC_BIT  = 5;
  localparam logic [STAT_W-1:0] STAT_USED =
    STAT_W'((1 << OBF_BIT) | (1 << SRC_BIT));
endpackage

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/rxd_ring.sv
module rxd_ring #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic          avail_o,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] ovr_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic          empty, full, do_wr, do_rd;

  assign wptr_nx = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
  assign rptr_nx = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_nx == rptr_q);
  // a write colliding with full is dropped even if a read pops the same cycle
  assign do_wr   = en_i && wr_i && !full;
  assign do_rd   = en_i && rd_i && !empty;
  assign avail_o = !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (!en_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr) wptr_q <= wptr_nx;
      if (do_rd) rptr_q <= rptr_nx;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_i)  rdata_o <= do_rd ? mem_q[rptr_q] : '0;
  end

  rxd_sat_cnt #(.W(CW)) u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (en_i && wr_i && full),
    .cnt_o  (ovr_o)
  );
endmodule

// File: rtl/rx_ring_demux.sv
module rx_ring_demux
  import rxd_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           svc_i,
  input  logic [STAT_W-1:0]              stat_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic                           data_rd_o,
  input  logic [NUM_CH-1:0]              chan_en_i,
  input  logic [NUM_CH-1:0]              rd_i,
  output logic [NUM_CH-1:0]              avail_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   overrun_o,
  output logic [CNT_W-1:0]               unclaimed_o
);
  logic take, unused_stat;
  logic [NUM_CH-1:0] wr_sel;

  assign take        = svc_i && stat_i[OBF_BIT];
  assign data_rd_o   = take;
  assign unused_stat = ^(stat_i & ~STAT_USED);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_sel[c] = take && (stat_i[SRC_BIT] == c[0]);

    rxd_ring #(.DEPTH(RING_D), .DW(DATA_W), .CW(CNT_W)) u_ring (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (chan_en_i[c]),
      .wr_i    (wr_sel[c]),
      .wdata_i (data_i),
      .rd_i    (rd_i[c]),
      .avail_o (avail_o[c]),
      .rdata_o (rd_data_o[c]),
      .ovr_o   (overrun_o[c])
    );
  end

  rxd_sat_cnt #(.W(CNT_W)) u_unclaimed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (svc_i && !stat_i[OBF_BIT]),
    .cnt_o  (unclaimed_o)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
  import rxd_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           svc_i,
  input logic [STAT_W-1:0]              stat_i,
  input logic                           data_rd_o,
  input logic [NUM_CH-1:0]              chan_en_i,
  input logic [NUM_CH-1:0]              rd_i,
  input logic [NUM_CH-1:0]              avail_o,
  input logic [NUM_CH-1:0][DATA_W-1:0]  rd_data_o,
  input logic [NUM_CH-1:0][CNT_W-1:0]   overrun_o,
  input logic [CNT_W-1:0]               unclaimed_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_unclaimed_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !stat_i[OBF_BIT] && unclaimed_o != CMAX)
      |=> unclaimed_o == CNT_W'($past(unclaimed_o) + 1'b1));

  assert_unclaimed_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unclaimed_o == CMAX) |=> (unclaimed_o == CMAX));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_clear_on_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chan_en_i[c] |=> !avail_o[c]);

    assert_empty_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i[c] && !avail_o[c]) |=> (rd_data_o[c] == '0));

    assert_ovr_monotonic_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o[c] >= $past(overrun_o[c]));

    assert_disabled_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_i && stat_i[OBF_BIT] && (stat_i[SRC_BIT] == c[0]) && !chan_en_i[c])
        |=> $stable(overrun_o[c]));

    assert_avail_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!avail_o[c] && !(data_rd_o && stat_i[SRC_BIT] == c[0])) |=> !avail_o[c]);
  end
endmodule

bind rx_ring_demux rxd_checker u_rxd_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .svc_i       (svc_i),
  .stat_i      (stat_i),
  .data_rd_o   (data_rd_o),
  .chan_en_i   (chan_en_i),
  .rd_i        (rd_i),
  .avail_o     (avail_o),
  .rd_data_o   (rd_data_o),
  .overrun_o   (overrun_o),
  .unclaimed_o (unclaimed_o)
);

// File: tb/sim_rx_ring_demux.sv
module sim_rx_ring_demux;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 63;

  logic clk = 1'b0, rst_n = 1'b0, svc = 1'b0;
  logic [7:0] stat = '0, data = '0;
  logic data_rd;
  logic [1:0] en = '0, rd = '0, avail;
  logic [1:0][7:0] rd_data;
  logic [1:0][15:0] ovr;
  logic [15:0] unc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q0[$], exp_q1[$];
  int exp_ovr[2] = '{0, 0};
  int exp_unc = 0;
  logic [1:0] rd_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_demux u0 (
    .clk_i(clk), .rst_ni(rst_n), .svc_i(svc), .stat_i(stat), .data_i(data),
    .data_rd_o(data_rd), .chan_en_i(en), .rd_i(rd), .avail_o(avail),
    .rd_data_o(rd_data), .overrun_o(ovr), .unclaimed_o(unc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qsize(input int c);
    return (c == 0) ? exp_q0.size() : exp_q1.size();
  endfunction

  // driver: one service event, expectations pushed into the scoreboard
  task automatic push(input logic [7:0] st, input logic [7:0] d);
    @(negedge clk);
    svc = 1'b1; stat = st; data = d;
    #1 chk("R3 data_rd", int'(data_rd), int'(st[0]));
    if (st[0]) begin
      int c = st[5] ? 1 : 0;
      if (en[c]) begin
        if (qsize(c) == CAP) begin
          if (exp_ovr[c] < 65535) exp_ovr[c]++;
        end else if (c == 0) exp_q0.push_back(d);
        else exp_q1.push_back(d);
      end
    end else if (exp_unc < 65535) exp_unc++;
    @(negedge clk);
    svc = 1'b0; stat = '0;
  endtask

  task automatic rd_ch(input int c);
    @(negedge clk);
    rd[c] = 1'b1;
    @(negedge clk);
    rd[c] = 1'b0;
  endtask

  task automatic set_en(input int c, input logic v);
    @(negedge clk);
    en[c] = v;
    if (!v) begin
      if (c == 0) exp_q0.delete(); else exp_q1.delete();
    end
    @(negedge clk);
  endtask

  task automatic state(input string req);
    #1;
    for (int c = 0; c < 2; c++) begin
      chk({req, " avail"}, int'(avail[c]), int'(qsize(c) != 0));
      chk({req, " ovr"}, int'(ovr[c]), exp_ovr[c]);
    end
    chk({req, " unclaimed"}, int'(unc), exp_unc);
  endtask

  // monitor: compare registered read data the cycle after each strobe
  always @(posedge clk) rd_seen <= rst_n ? rd : 2'b00;
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rd_seen[c]) begin
        logic [7:0] e;
        if (c == 0) e = (exp_q0.size() != 0) ? exp_q0.pop_front() : 8'h00;
        else        e = (exp_q1.size() != 0) ? exp_q1.pop_front() : 8'h00;
        chk($sformatf("R4/R7 ch%0d read", c), int'(rd_data[c]), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 avail", int'(avail), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 ovr", int'(ovr), 0);
    chk("R1 unclaimed", int'(unc), 0);
    rst_n = 1'b1;
    set_en(0, 1'b1);
    set_en(1, 1'b1);

    // R2 routing, R9 available flag
    push(8'h01, 8'hA1);
    #1 chk("R9 avail rises ch0", int'(avail), 1);
    push(8'h21, 8'hB1);
    push(8'h05, 8'hA2);
    push(8'h25, 8'hB2);
    push(8'h01, 8'hA3);
    state("R2");
    for (int i = 0; i < 3; i++) rd_ch(0);
    for (int i = 0; i < 2; i++) rd_ch(1);
    state("R4 drained");
    // R7 empty read
    rd_ch(0);
    rd_ch(1);
    state("R7");

    // R3 no byte waiting
    push(8'h20, 8'h55);
    push(8'h00, 8'h66);
    state("R3");

    // R6 disabled channel
    set_en(1, 1'b0);
    push(8'h21, 8'h77);
    push(8'h21, 8'h78);
    state("R6");
    set_en(1, 1'b1);
    state("R6 re-enable");

    // R4/R5 capacity and overrun
    for (int i = 0; i < 66; i++) push(8'h01, 8'(i + 16));
    state("R5 full");
    for (int i = 0; i < 64; i++) rd_ch(0);
    state("R5 drained");

    // R11 wrap
    for (int i = 0; i < 150; i++) begin
      push(8'h21, 8'(i * 7 + 3));
      if (i % 3 == 2) begin
        rd_ch(1);
        rd_ch(1);
      end
    end
    while (qsize(1) != 0) rd_ch(1);
    state("R11");

    // R8 clear on disable
    for (int i = 0; i < 5; i++) push(8'h21, 8'(200 + i));
    set_en(1, 1'b0);
    set_en(1, 1'b1);
    state("R8");
    rd_ch(1);
    push(8'h21, 8'hEE);
    rd_ch(1);
    state("R8 after");

    // R10 saturation
    for (int i = 0; i < CAP; i++) push(8'h01, 8'(i));
    @(negedge clk);
    svc = 1'b1; stat = 8'h01; data = 8'hFF;
    repeat (65540) @(negedge clk);
    svc = 1'b0; stat = '0;
    exp_ovr[0] = 65535;
    state("R10");
    for (int i = 0; i < 2; i++) rd_ch(0);
    #1 chk("R10 ch0 still holds", int'(avail[0]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule